// File: doc/BRIEF.md
# Flash Command-Mode Tracker with Query-Table Select

This block follows the command-interface mode of a parallel flash device. It holds one of four modes: array read, autoselect, query-table read, or busy (an embedded program or erase algorithm is running). It looks at qualified write cycles to decide when the device moves into or out of the query-table mode. It also drives the read-path steering that chooses between array contents and the query table.

The host sees only writes and reads. A write carries an address and a command byte. The bus width (byte or word) decides which address a mode-entry command has to hit. The flag from the embedded-algorithm engine overrides every write for as long as it is high. On the read side, the block turns the read address into a query-table index. In byte mode every table entry takes up two byte addresses, so the index is the read address shifted right by one bit.

Top module: `flash_cfi_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `mode` becomes 0 (array read) and `rd_sel_query` is 0, whatever writes happen in those cycles.
- R2: In word mode (`byte_mode`=0), a write of 98h to address 055h from array read sets `mode` to 2 (query table) on the next clock.
- R3: In byte mode (`byte_mode`=1), a write of 98h to address 0AAh from array read sets `mode` to 2 on the next clock.
- R4: A 98h or 90h write to any address other than the command address for the current bus width (055h in word mode, 0AAh in byte mode) leaves `mode` unchanged.
- R5: A write of 90h to the command address from array read sets `mode` to 1 (autoselect). A write of 98h to the command address from autoselect sets `mode` to 2.
- R6: When `algo_busy` is high at a clock edge, `mode` is 3 (busy) after that edge, and every write in that cycle is ignored. When `mode` is 3 and `algo_busy` is low at an edge, `mode` returns to 0 and that cycle's write is ignored.
- R7: When `mode` is 2, the only write that changes it is F0h, which sets `mode` to 0 at any address. Writes of 98h, 90h or any other byte leave it at 2.
- R8: A write of F0h at any address from autoselect sets `mode` to 0. F0h in array read leaves `mode` at 0.
- R9: `rd_sel_query` is 1 exactly when `mode` is 2, so reads take query-table data. Otherwise reads take array data.
- R10: `qry_idx` equals `rd_addr[6:0]` in word mode and `rd_addr[7:1]` in byte mode, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Qualified write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write command byte |
| byte_mode | input | 1 | 1 = byte-wide bus, 0 = word-wide bus |
| algo_busy | input | 1 | Embedded program/erase algorithm running |
| rd_addr | input | 8 | Read address |
| mode | output | 2 | 0 array, 1 autoselect, 2 query table, 3 busy |
| rd_sel_query | output | 1 | 1 selects query-table data on reads |
| qry_idx | output | 7 | Query-table index derived from `rd_addr` |

## Verification
The bench sends 98h to the word-mode address while byte mode is selected, and the reverse. A design that matched either address regardless of bus width would enter the query mode here and fail. It also writes 98h and 90h inside query mode, and a design that let those commands leave or re-enter a mode would show it. It writes 98h while the busy flag is high and in the cycle the flag drops. A design that let writes win over busy would enter query mode straight out of an algorithm. The bench applies F0h at random addresses to show that reset ignores the address. It also checks the shifted query index in byte mode, which a design without the shift would get wrong.

// File: rtl/fcq_pkg.sv
package fcq_pkg;

    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'd0,
        MODE_AUTOSEL = 2'd1,
        MODE_QUERY   = 2'd2,
        MODE_BUSY    = 2'd3
    } fcq_mode_e;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_QUERY   = 3'd1,
        CMD_AUTOSEL = 3'd2,
        CMD_RESET   = 3'd3,
        CMD_OTHER   = 3'd4
    } fcq_cmd_e;

    typedef struct packed {
        logic       strobe;
        logic       addr_hit;
        logic [7:0] opcode;
    } fcq_wr_s;

    localparam logic [7:0] OPC_QUERY   = 8'h98;
    localparam logic [7:0] OPC_AUTOSEL = 8'h90;
    localparam logic [7:0] OPC_RESET   = 8'hF0;

    localparam int unsigned WORD_CMD_ADDR = 32'h55;
    localparam int unsigned BYTE_CMD_ADDR = 32'hAA;

    // Reset opcode wins at any address; the others need the command address.
    function automatic fcq_cmd_e classify(input fcq_wr_s w);
        fcq_cmd_e k;
        if (!w.strobe)
            k = CMD_NONE;
        else if (w.opcode == OPC_RESET)
            k = CMD_RESET;
        else if (w.addr_hit && w.opcode == OPC_QUERY)
            k = CMD_QUERY;
        else if (w.addr_hit && w.opcode == OPC_AUTOSEL)
            k = CMD_AUTOSEL;
        else
            k = CMD_OTHER;
        return k;
    endfunction

endpackage

// File: rtl/fcq_cmd_decode.sv
module fcq_cmd_decode
    import fcq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              byte_mode,
    output fcq_cmd_e          cmd
);
    localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(WORD_CMD_ADDR);
    localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(BYTE_CMD_ADDR);

    fcq_wr_s wr;

    always_comb begin
        wr.strobe   = wr_en;
        wr.opcode   = wr_data;
        wr.addr_hit = (wr_addr == (byte_mode ? BYTE_ADDR : WORD_ADDR));
        cmd         = classify(wr);
    end

endmodule

// File: rtl/fcq_mode_fsm.sv
module fcq_mode_fsm
    import fcq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fcq_cmd_e  cmd,
    input  logic      algo_busy,
    output fcq_mode_e mode_q
);
    fcq_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (algo_busy) begin
            mode_d = MODE_BUSY;
        end else begin
            unique case (mode_q)
                MODE_ARRAY: begin
                    if (cmd == CMD_QUERY)
                        mode_d = MODE_QUERY;
                    else if (cmd == CMD_AUTOSEL)
                        mode_d = MODE_AUTOSEL;
                end
                MODE_AUTOSEL: begin
                    if (cmd == CMD_QUERY)
                        mode_d = MODE_QUERY;
                    else if (cmd == CMD_RESET)
                        mode_d = MODE_ARRAY;
                end
                MODE_QUERY: begin
                    if (cmd == CMD_RESET)
                        mode_d = MODE_ARRAY;
                end
                MODE_BUSY: mode_d = MODE_ARRAY;
                default:   mode_d = MODE_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_ARRAY;
        else
            mode_q <= mode_d;
    end

    // R6
    busy_wins_chk: assert property (@(posedge clk) disable iff (rst)
        algo_busy |=> (mode_q == MODE_BUSY));

    // R6
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BUSY && !algo_busy) |=> (mode_q == MODE_ARRAY));

    // R5
    query_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (!algo_busy && cmd == CMD_QUERY &&
         (mode_q == MODE_ARRAY || mode_q == MODE_AUTOSEL)) |=> (mode_q == MODE_QUERY));

    // R7
    query_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!algo_busy && mode_q == MODE_QUERY && cmd != CMD_RESET) |=> (mode_q == MODE_QUERY));

endmodule

// File: rtl/fcq_read_sel.sv
module fcq_read_sel
    import fcq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  fcq_mode_e         mode_q,
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_sel_query,
    output logic [ADDR_W-2:0] qry_idx
);
    always_comb begin
        rd_sel_query = (mode_q == MODE_QUERY);
        qry_idx      = byte_mode ? rd_addr[ADDR_W-1:1] : rd_addr[ADDR_W-2:0];
    end

endmodule

// File: rtl/flash_cfi_mode_ctrl.sv
module flash_cfi_mode_ctrl
    import fcq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              byte_mode,
    input  logic              algo_busy,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        mode,
    output logic              rd_sel_query,
    output logic [ADDR_W-2:0] qry_idx
);
    fcq_cmd_e  cmd;
    fcq_mode_e mode_q;

    fcq_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .byte_mode (byte_mode),
        .cmd       (cmd)
    );

    fcq_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .algo_busy (algo_busy),
        .mode_q    (mode_q)
    );

    fcq_read_sel #(.ADDR_W(ADDR_W)) u_rsel (
        .mode_q       (mode_q),
        .byte_mode    (byte_mode),
        .rd_addr      (rd_addr),
        .rd_sel_query (rd_sel_query),
        .qry_idx      (qry_idx)
    );

    assign mode = mode_q;

endmodule

// File: tb/sim_flash_cfi_mode_ctrl.sv
module sim_flash_cfi_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       byte_mode = 1'b0;
    logic       algo_busy = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [1:0] mode;
    logic       rd_sel_query;
    logic [6:0] qry_idx;

    int n_checks = 0;
    int n_fail   = 0;
    logic [1:0] exp_mode = 2'd0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cfi_mode_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_mode(byte_mode), .algo_busy(algo_busy), .rd_addr(rd_addr),
        .mode(mode), .rd_sel_query(rd_sel_query), .qry_idx(qry_idx)
    );

    // Expected next mode, written from the requirement list.
    function automatic logic [1:0] ref_next(input logic [1:0] m, input logic we,
                                            input logic [7:0] a, input logic [7:0] d,
                                            input logic bm, input logic busy);
        logic at_cmd;
        at_cmd = bm ? (a == 8'hAA) : (a == 8'h55);
        if (busy) return 2'd3;                        // R6
        if (m == 2'd3) return 2'd0;                   // R6
        if (!we) return m;
        if (d == 8'hF0) return 2'd0;                  // R7, R8
        if (m == 2'd2) return 2'd2;                   // R7
        if (at_cmd && d == 8'h98) return 2'd2;        // R2, R3, R5
        if (m == 2'd0 && at_cmd && d == 8'h90) return 2'd1; // R5
        return m;                                     // R4
    endfunction

    function automatic string ref_tag(input logic [1:0] m, input logic we,
                                      input logic [7:0] d, input logic bm, input logic busy);
        if (busy || m == 2'd3) return "R6";
        if (m == 2'd2) return "R7";
        if (we && d == 8'hF0) return "R8";
        if (m == 2'd1) return "R5";
        if (we && (d == 8'h98 || d == 8'h90)) return bm ? "R3/R4" : "R2/R4";
        return "R4";
    endfunction

    task automatic check(input string tag);
        logic [6:0] exp_idx;
        exp_idx = byte_mode ? rd_addr[7:1] : rd_addr[6:0];
        n_checks++;
        if (mode !== exp_mode) begin
            n_fail++;
            $display("FAIL %s mode actual=%0d expected=%0d", tag, mode, exp_mode);
        end
        n_checks++;
        if (rd_sel_query !== (exp_mode == 2'd2)) begin
            n_fail++;
            $display("FAIL R9 rd_sel_query actual=%0b expected=%0b", rd_sel_query, exp_mode == 2'd2);
        end
        n_checks++;
        if (qry_idx !== exp_idx) begin
            n_fail++;
            $display("FAIL R10 qry_idx actual=%0h expected=%0h", qry_idx, exp_idx);
        end
    endtask

    // Called at a falling edge: drive, predict, wait one cycle, check.
    task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                       input logic bm, input logic busy, input string tag);
        string t;
        wr_en = we; wr_addr = a; wr_data = d; byte_mode = bm; algo_busy = busy;
        rd_addr = 8'($urandom);
        t = (tag == "") ? ref_tag(exp_mode, we, d, bm, busy) : tag;
        exp_mode = ref_next(exp_mode, we, a, d, bm, busy);
        @(negedge clk);
        check(t);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        // R1: reset holds array read even with an entry write applied
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h55; wr_data = 8'h98;
        repeat (3) @(negedge clk);
        exp_mode = 2'd0;
        check("R1");
        rst = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R1");

        // R2 word entry, R7 stays on non-reset writes, R7 F0 exit
        cyc(1, 8'h55, 8'h98, 0, 0, "R2");
        cyc(1, 8'h55, 8'h90, 0, 0, "R7");
        cyc(1, 8'h55, 8'h98, 0, 0, "R7");
        cyc(1, 8'h13, 8'h00, 0, 0, "R7");
        cyc(1, 8'h77, 8'hF0, 0, 0, "R7");
        // R4 wrong address per bus width
        cyc(1, 8'hAA, 8'h98, 0, 0, "R4");
        cyc(1, 8'h55, 8'h98, 1, 0, "R4");
        cyc(1, 8'h55, 8'h90, 1, 0, "R4");
        // R3 byte entry, R10 byte index
        cyc(1, 8'hAA, 8'h98, 1, 0, "R3");
        cyc(0, 8'h00, 8'h00, 1, 0, "R10");
        cyc(1, 8'h01, 8'hF0, 1, 0, "R7");
        // R5 autoselect then query; R8 reset from autoselect
        cyc(1, 8'h55, 8'h90, 0, 0, "R5");
        cyc(1, 8'h12, 8'h98, 0, 0, "R4");
        cyc(1, 8'h55, 8'h98, 0, 0, "R5");
        cyc(1, 8'h00, 8'hF0, 0, 0, "R7");
        cyc(1, 8'hAA, 8'h90, 1, 0, "R5");
        cyc(1, 8'hC3, 8'hF0, 1, 0, "R8");
        cyc(1, 8'h00, 8'hF0, 0, 0, "R8");
        // R6 busy blocks entry, release ignores the write
        cyc(1, 8'h55, 8'h98, 0, 1, "R6");
        cyc(1, 8'h55, 8'h98, 0, 1, "R6");
        cyc(1, 8'h55, 8'h98, 0, 0, "R6");
        cyc(1, 8'h55, 8'h98, 0, 0, "R2");
        cyc(0, 8'h00, 8'h00, 0, 1, "R6");
        cyc(0, 8'h00, 8'h00, 0, 0, "R6");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a, d;
            logic bm, we, busy;
            int unsigned r;
            r = $urandom_range(0, 9);
            a = (r < 4) ? 8'h55 : (r < 8) ? 8'hAA : 8'($urandom);
            r = $urandom_range(0, 9);
            d = (r < 3) ? 8'h98 : (r < 5) ? 8'h90 : (r < 7) ? 8'hF0 : 8'($urandom);
            bm = 1'($urandom);
            we = ($urandom_range(0, 3) != 0);
            busy = ($urandom_range(0, 19) == 0);
            cyc(we, a, d, bm, busy, "");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule